// File: doc/BRIEF.md
# Self-Checking Modular Adder With Byte-Parity Prediction

This block adds two 32-bit operands modulo 2^32 and delivers the sum together with one predicted even-parity bit per byte, so that the result can travel onwards in a parity-protected datapath. Each operand arrives with its own byte parities. The adder also raises a concurrent error indication on a two-rail pair, so that a fault in the logic shows up while the block is in normal use.

The sum path and the carry path are checked by separate logic. The carry chain is built twice. The two copies meet, bit by bit, in a two-rail comparison tree with one copy fed in inverted. That tree's true rail also yields the XOR of the carry bits, and this value is the carry parity used to predict each sum byte parity. The predicted byte parities are then compared with parities recomputed from the sum bits. All of the comparison results are merged into one output pair, which is complementary when no error is present. Two fault-injection masks let a test environment flip any sum bit or any carry bit of the primary chain.

Top module: `pp_adder`

## Requirements
- R1: One clock edge after the operands are presented, `sum_o` equals (`op_a` + `op_b`) mod 2^32 XOR `flip_sum`, provided `flip_carry` is zero. The carry out of bit 31 is discarded.
- R2: `sum_par_o[k]` is the even parity (the XOR) of bits 8k+7..8k of `sum_o`. This holds whenever the operand parities are correct and both fault masks are zero.
- R3: When the operand byte parities are correct and both fault masks are zero, `chk_t_o` and `chk_f_o` take opposite values, which means no error.
- R4: A flip of any single sum bit through `flip_sum` makes `chk_t_o` equal to `chk_f_o` on the following cycle.
- R5: A flip of any single carry-in bit of the primary carry chain through `flip_carry` makes `chk_t_o` equal to `chk_f_o` on the following cycle.
- R6: If exactly one bit of `par_a` or `par_b` disagrees with the XOR of its operand byte (bit k covers bits 8k+7..8k), the result is `chk_t_o` equal to `chk_f_o` on the following cycle.
- R7: While `rst_n` is low, the outputs are `sum_o` = 0, `sum_par_o` = 0, `chk_t_o` = 0 and `chk_f_o` = 1.
- R8: The carry into bit 0 is zero. Wrap-around cases such as 0xFFFFFFFF + 1 = 0 and 0x80000000 + 0x80000000 = 0 produce the correct sum and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| par_a | input | 4 | Byte parities of op_a |
| par_b | input | 4 | Byte parities of op_b |
| flip_sum | input | 32 | Fault mask XORed onto the sum bits |
| flip_carry | input | 32 | Fault mask XORed onto the primary carry-in bits |
| sum_o | output | 32 | Registered sum |
| sum_par_o | output | 4 | Registered predicted byte parities of the sum |
| chk_t_o | output | 1 | True rail of the error pair |
| chk_f_o | output | 1 | False rail of the error pair; equal rails signal an error |

## Verification
The hardest condition to reach is a carry-path fault. A flipped carry changes both the sum bit and the carry parity used for the prediction, so the sum-parity comparison stays silent. Only the duplicated-chain comparison can catch it. The bench walks a one-hot mask across all 32 carry-in positions, and across all 32 sum positions, on an operand pair with long carry runs. It requires detection in every case. It also walks single parity-bit corruptions across both operands and runs random fault-free operands that must never raise an error.

// File: rtl/pp_adder_pkg.sv
package pp_adder_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANE_W = 8;

    typedef struct packed {
        logic t;
        logic f;
    } rail_pair_t;

    // Two-rail merge: the output is complementary only if both inputs are.
    // The true rail carries the XOR of the input true rails.
    function automatic rail_pair_t rail_merge(input rail_pair_t x, input rail_pair_t y);
        rail_pair_t z;
        z.t = (x.t & y.f) | (x.f & y.t);
        z.f = (x.t & y.t) | (x.f & y.f);
        return z;
    endfunction

endpackage

// File: rtl/pp_carry_chain.sv
module pp_carry_chain #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] cin
);
    // cin[i] is the carry entering bit i. The carry into bit 0 is tied low.
    assign cin[0] = 1'b0;

    for (genvar i = 1; i < WIDTH; i++) begin : g_ripple
        logic gen_b;
        logic prop_b;
        assign gen_b  = x[i-1] & y[i-1];
        assign prop_b = x[i-1] ^ y[i-1];
        assign cin[i] = gen_b | (prop_b & cin[i-1]);
    end

endmodule

// File: rtl/pp_rail_tree.sv
module pp_rail_tree
    import pp_adder_pkg::*;
#(
    parameter int unsigned LEAVES = 8
) (
    input  logic [LEAVES-1:0] in_t,
    input  logic [LEAVES-1:0] in_f,
    output logic              out_t,
    output logic              out_f
);
    // Heap-ordered tree. Node j (j >= 1) is stored at index j-1,
    // its children are nodes 2j and 2j+1, and the leaves are nodes LEAVES..2*LEAVES-1.
    localparam int unsigned NODES = 2 * LEAVES - 1;

    rail_pair_t node [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        assign node[LEAVES + i - 1] = '{t: in_t[i], f: in_f[i]};
    end

    for (genvar j = 1; j < LEAVES; j++) begin : g_merge
        assign node[j-1] = rail_merge(node[2*j-1], node[2*j]);
    end

    assign out_t = node[0].t;
    assign out_f = node[0].f;

endmodule

// File: rtl/pp_adder.sv
module pp_adder
    import pp_adder_pkg::*;
#(
    parameter int unsigned WIDTH  = DATA_W,
    parameter int unsigned LANE   = LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WIDTH-1:0]        op_a,
    input  logic [WIDTH-1:0]        op_b,
    input  logic [WIDTH/LANE-1:0]   par_a,
    input  logic [WIDTH/LANE-1:0]   par_b,
    input  logic [WIDTH-1:0]        flip_sum,
    input  logic [WIDTH-1:0]        flip_carry,
    output logic [WIDTH-1:0]        sum_o,
    output logic [WIDTH/LANE-1:0]   sum_par_o,
    output logic                    chk_t_o,
    output logic                    chk_f_o
);
    localparam int unsigned NLANE = WIDTH / LANE;
    localparam int unsigned NPAIR = 2 * NLANE;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic [NLANE-1:0] par;
        logic             chk_t;
        logic             chk_f;
    } out_state_t;

    out_state_t st_d, st_q;

    // Two independent carry chains.
    logic [WIDTH-1:0] cin_main, cin_dup, cin_used;

    pp_carry_chain #(.WIDTH(WIDTH)) u_chain_main (.x(op_a), .y(op_b), .cin(cin_main));
    pp_carry_chain #(.WIDTH(WIDTH)) u_chain_dup  (.x(op_a), .y(op_b), .cin(cin_dup));

    assign cin_used = cin_main ^ flip_carry;

    // Sum path.
    logic [WIDTH-1:0] sum_raw;
    assign sum_raw = op_a ^ op_b ^ cin_used ^ flip_sum;

    // Per-lane carry comparison. Its true rail is the lane carry parity.
    logic [NLANE-1:0] lane_ct, lane_cf;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        pp_rail_tree #(.LEAVES(LANE)) u_carry_cmp (
            .in_t  (cin_used[k*LANE +: LANE]),
            .in_f  (~cin_dup[k*LANE +: LANE]),
            .out_t (lane_ct[k]),
            .out_f (lane_cf[k])
        );
    end

    // Parity prediction and recomputation.
    logic [NLANE-1:0] par_pred, par_calc;

    always_comb begin
        for (int k = 0; k < NLANE; k++) begin
            par_pred[k] = par_a[k] ^ par_b[k] ^ lane_ct[k];
            par_calc[k] = ^sum_raw[k*LANE +: LANE];
        end
    end

    // Final merge of sum-parity pairs and carry-comparison pairs.
    logic [NPAIR-1:0] leaf_t, leaf_f;
    logic             fin_t, fin_f;

    assign leaf_t = {lane_ct, par_pred};
    assign leaf_f = {lane_cf, ~par_calc};

    pp_rail_tree #(.LEAVES(NPAIR)) u_final_cmp (
        .in_t  (leaf_t),
        .in_f  (leaf_f),
        .out_t (fin_t),
        .out_f (fin_f)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sum   = sum_raw;
        st_d.par   = par_pred;
        st_d.chk_t = fin_t;
        st_d.chk_f = fin_f;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sum: '0, par: '0, chk_t: 1'b0, chk_f: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o     = st_q.sum;
    assign sum_par_o = st_q.par;
    assign chk_t_o   = st_q.chk_t;
    assign chk_f_o   = st_q.chk_f;

endmodule

// File: rtl/pp_adder_chk.sv
module pp_adder_chk #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned LANE  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [WIDTH-1:0]      op_a,
    input logic [WIDTH-1:0]      op_b,
    input logic [WIDTH/LANE-1:0] par_a,
    input logic [WIDTH/LANE-1:0] par_b,
    input logic [WIDTH-1:0]      flip_sum,
    input logic [WIDTH-1:0]      flip_carry,
    input logic [WIDTH-1:0]      sum_o,
    input logic [WIDTH/LANE-1:0] sum_par_o,
    input logic                  chk_t_o,
    input logic                  chk_f_o
);
    localparam int unsigned NLANE = WIDTH / LANE;

    function automatic logic [NLANE-1:0] lane_par(input logic [WIDTH-1:0] v);
        logic [NLANE-1:0] p;
        for (int k = 0; k < NLANE; k++) p[k] = ^v[k*LANE +: LANE];
        return p;
    endfunction

    logic clean_in;
    assign clean_in = (flip_sum == '0) && (flip_carry == '0) &&
                      (par_a == lane_par(op_a)) && (par_b == lane_par(op_b));

    // R1
    sum_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_carry == '0) |=> (sum_o == $past((op_a + op_b) ^ flip_sum)));

    // R2
    sum_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clean_in |=> (sum_par_o == lane_par(sum_o)));

    // R3
    no_false_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clean_in |=> (chk_t_o != chk_f_o));

    // R4
    sum_fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(flip_sum) == 1) && (flip_carry == '0)) |=> (chk_t_o == chk_f_o));

    // R5
    carry_fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(flip_carry) == 1) && (flip_sum == '0)) |=> (chk_t_o == chk_f_o));

endmodule

bind pp_adder pp_adder_chk #(.WIDTH(WIDTH), .LANE(LANE)) u_pp_adder_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .par_a      (par_a),
    .par_b      (par_b),
    .flip_sum   (flip_sum),
    .flip_carry (flip_carry),
    .sum_o      (sum_o),
    .sum_par_o  (sum_par_o),
    .chk_t_o    (chk_t_o),
    .chk_f_o    (chk_f_o)
);

// File: tb/pp_adder_tb.sv
module pp_adder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, flip_sum = '0, flip_carry = '0;
    logic [3:0]  par_a = '0, par_b = '0;
    logic [31:0] sum_o;
    logic [3:0]  sum_par_o;
    logic        chk_t_o, chk_f_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pp_adder u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .par_a(par_a), .par_b(par_b), .flip_sum(flip_sum), .flip_carry(flip_carry),
        .sum_o(sum_o), .sum_par_o(sum_par_o), .chk_t_o(chk_t_o), .chk_f_o(chk_f_o)
    );

    // {a, b, expected sum}
    localparam int NVEC = 8;
    localparam logic [95:0] VECS [NVEC] = '{
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        {32'h1234_5678, 32'h9ABC_DEF0, 32'hACF1_3568},
        {32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
        {32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE},
        {32'h00FF_00FF, 32'h0001_0001, 32'h0100_0100},
        {32'hDEAD_BEEF, 32'h0123_4567, 32'hDFD1_0456}
    };

    function automatic logic [3:0] bpar(input logic [31:0] v);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ^v[k*8 +: 8];
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample on the next falling edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] ea, input logic [3:0] eb,
                         input logic [31:0] fs, input logic [31:0] fc);
        op_a = a; op_b = b;
        par_a = bpar(a) ^ ea; par_b = bpar(b) ^ eb;
        flip_sum = fs; flip_carry = fc;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic is_err();
        return chk_t_o == chk_f_o;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 sum", sum_o, 32'h0);
        check("R7 par", {28'h0, sum_par_o}, 32'h0);
        check("R7 rails", {30'h0, chk_t_o, chk_f_o}, 32'h1);
        rst_n = 1'b1;

        // R1 R2 R3 R8: vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][95:64], VECS[i][63:32], 4'h0, 4'h0, '0, '0);
            check("R1 sum", sum_o, VECS[i][31:0]);
            check("R2 par", {28'h0, sum_par_o}, {28'h0, bpar(VECS[i][31:0])});
            check("R3 no error", {31'h0, is_err()}, 32'h0);
        end

        // R8: wrap-around with carry into bit 0 at zero
        apply(32'hFFFF_FFFF, 32'h0000_0001, 4'h0, 4'h0, '0, '0);
        check("R8 wrap sum", sum_o, 32'h0);
        check("R8 wrap no error", {31'h0, is_err()}, 32'h0);

        // R3: random fault-free operands
        for (int i = 0; i < 200; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            apply(ra, rb, 4'h0, 4'h0, '0, '0);
            check("R1 random sum", sum_o, ra + rb);
            check("R3 random no error", {31'h0, is_err()}, 32'h0);
        end

        // R4: single sum-bit flips
        for (int i = 0; i < 32; i++) begin
            apply(32'h7FFF_FFFF, 32'h0000_0001, 4'h0, 4'h0, 32'h1 << i, '0);
            check("R4 sum flip value", sum_o, 32'h8000_0000 ^ (32'h1 << i));
            check("R4 sum flip flagged", {31'h0, is_err()}, 32'h1);
        end

        // R5: single carry-bit flips
        for (int i = 0; i < 32; i++) begin
            apply(32'h5555_5555, 32'h2AAA_AAAB, 4'h0, 4'h0, '0, 32'h1 << i);
            check("R5 carry flip flagged", {31'h0, is_err()}, 32'h1);
        end

        // R6: single operand parity corruptions
        for (int k = 0; k < 4; k++) begin
            apply(32'h1234_5678, 32'h9ABC_DEF0, 4'h1 << k, 4'h0, '0, '0);
            check("R6 par_a flagged", {31'h0, is_err()}, 32'h1);
            apply(32'h1234_5678, 32'h9ABC_DEF0, 4'h0, 4'h1 << k, '0, '0);
            check("R6 par_b flagged", {31'h0, is_err()}, 32'h1);
        end

        // R3: recovery after faults are removed
        apply(32'hDEAD_BEEF, 32'h0123_4567, 4'h0, 4'h0, '0, '0);
        check("R3 recovery", {31'h0, is_err()}, 32'h0);

        // R7: reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 reset again sum", sum_o, 32'h0);
        check("R7 reset again rails", {30'h0, chk_t_o, chk_f_o}, 32'h1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule